// File: doc/BRIEF.md
# SD Host Single-Segment DMA Engine

This block is the data mover inside an SD/SDIO host controller. Software programs a transfer through a small register file of 64-bit words. It sets a direction, an address stepping mode and an 8-byte-aligned start address, then writes a start bit. The engine then moves 64-bit beats between a system memory port and the card data path. The host controller supplies the block count and the block size. The engine issues exactly (count × size) / 8 beats over one contiguous region, with no chaining.

Channel 0 serves write commands and moves memory data to the card. Channel 1 serves read commands and moves card data to memory. Each beat completes on a valid/ready handshake and passes straight through, with no buffering. Completion and error events set sticky per-channel status bits. Each set of status bits has a mask, and the unmasked bits combine into one level interrupt. Each channel has an active-low reset bit. Clearing it aborts a running transfer; setting it again releases the channel.

Top module: `sd_idma_engine`

## Requirements
- R1: After reset: mode, start address, both status words and both masks read 0. The channel-reset word reads 0x300 (both channels released). irq_o is low and no valid or ready output is asserted.
- R2: The mode word (offset 0x820) keeps bit 16 (channel: 0 = memory to card, 1 = card to memory), bits 5:4 (bus-width field) and bit 0 (1 = increment address). It reads back only those bits.
- R3: A write with bit 0 set to the control word (0x828) starts a transfer on the selected channel. On channel 0 a beat fires when mem_rvalid_i and card_tx_ready_i are both high, and card_tx_data_o equals mem_rdata_i. On channel 1 a beat fires when card_rx_valid_i and mem_wready_i are both high, and mem_wdata_o equals card_rx_data_i. Only one direction is ever active.
- R4: A transfer issues exactly blk_cnt_i × blk_size_i / 8 beats. If that count is zero, the transfer completes at once with no beats.
- R5: Beat k presents mem_addr_o = start + 8k when increment mode is on. When it is off, every beat presents the start address.
- R6: After the last beat, completion status (0x840) bit 16 (channel 0) or bit 17 (channel 1) is set.
- R7: A start with start address (0x880) bits 2:0 not zero sets error status (0x850) bit 16 or 17 for the selected channel. No beat is issued and no completion bit is set.
- R8: A write to a status word keeps only the bits written as 1, so writing zero clears it. A hardware set in the same cycle as a clear wins.
- R9: Reset word (0x830) bit 8 (channel 0) and bit 9 (channel 1) are active low. Clearing a running channel's bit aborts it without a completion bit. A start on a channel held in reset is ignored.
- R10: A start written while a transfer runs is ignored. Mode and address are captured at start, so later writes to them do not change the running transfer.
- R11: Mask words 0x848 and 0x858 use bits 16/17. irq_o is high exactly when some status bit is set and its mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register offset for read and write |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data at reg_addr_i |
| blk_cnt_i | input | 32 | Block count of the command |
| blk_size_i | input | 10 | Block size in bytes |
| mem_addr_o | output | 40 | Memory address of the current beat |
| mem_rvalid_i | input | 1 | Memory read data valid (channel 0) |
| mem_rready_o | output | 1 | Engine accepts memory read data |
| mem_rdata_i | input | 64 | Memory read data |
| mem_wvalid_o | output | 1 | Memory write data valid (channel 1) |
| mem_wready_i | input | 1 | Memory accepts write data |
| mem_wdata_o | output | 64 | Memory write data |
| card_tx_valid_o | output | 1 | Data valid toward the card |
| card_tx_ready_i | input | 1 | Card path accepts data |
| card_tx_data_o | output | 64 | Data toward the card |
| card_rx_valid_i | input | 1 | Data valid from the card |
| card_rx_ready_o | output | 1 | Engine accepts card data |
| card_rx_data_i | input | 64 | Data from the card |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can land in the same cycle: the engine setting a completion bit, and software writing that status word to clear it. The bench provokes this by aligning the final beat of a one-beat transfer so that the status-clearing write lands on the edge where the completion event is registered. It expects the new bit to survive while a previously set bit of the other channel is cleared. A second collision, a start arriving while a transfer runs, is judged by the addresses and beat count of the transfer in flight.

// File: rtl/sd_idma_pkg.sv
package sd_idma_pkg;
  localparam logic [11:0] OFS_MODE     = 12'h820;
  localparam logic [11:0] OFS_CTRL     = 12'h828;
  localparam logic [11:0] OFS_RST      = 12'h830;
  localparam logic [11:0] OFS_DONE     = 12'h840;
  localparam logic [11:0] OFS_DONE_MSK = 12'h848;
  localparam logic [11:0] OFS_ERR      = 12'h850;
  localparam logic [11:0] OFS_ERR_MSK  = 12'h858;
  localparam logic [11:0] OFS_ADDR     = 12'h880;

  typedef struct packed {
    logic       chan;   // 0: mem->card, 1: card->mem
    logic [1:0] width;
    logic       incr;
  } mode_t;
endpackage

// File: rtl/sd_idma_regs.sv
module sd_idma_regs
  import sd_idma_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [11:0]       addr_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output mode_t             mode_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              start_o,
  output logic [1:0]        rel_o,
  input  logic [1:0]        done_evt_i,
  input  logic [1:0]        err_evt_i,
  output logic              irq_o
);
  mode_t             mode_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        rel_q, done_q, err_q, dmsk_q, emsk_q;
  logic [1:0]        done_keep, err_keep;

  assign done_keep = (wr_i && addr_i == OFS_DONE) ? wdata_i[17:16] : 2'b11;
  assign err_keep  = (wr_i && addr_i == OFS_ERR)  ? wdata_i[17:16] : 2'b11;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      base_q <= '0;
      rel_q  <= 2'b11;
      dmsk_q <= '0;
      emsk_q <= '0;
      done_q <= '0;
      err_q  <= '0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          OFS_MODE:     mode_q <= '{chan: wdata_i[16], width: wdata_i[5:4], incr: wdata_i[0]};
          OFS_RST:      rel_q  <= wdata_i[9:8];
          OFS_DONE_MSK: dmsk_q <= wdata_i[17:16];
          OFS_ERR_MSK:  emsk_q <= wdata_i[17:16];
          OFS_ADDR:     base_q <= wdata_i[ADDR_W-1:0];
          default: ;
        endcase
      end
      // hardware set wins over a same-cycle clear
      done_q <= (done_q & done_keep) | done_evt_i;
      err_q  <= (err_q & err_keep) | err_evt_i;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_MODE:     rdata_o = {47'b0, mode_q.chan, 10'b0, mode_q.width, 3'b0, mode_q.incr};
      OFS_RST:      rdata_o = {54'b0, rel_q, 8'b0};
      OFS_DONE:     rdata_o = {46'b0, done_q, 16'b0};
      OFS_DONE_MSK: rdata_o = {46'b0, dmsk_q, 16'b0};
      OFS_ERR:      rdata_o = {46'b0, err_q, 16'b0};
      OFS_ERR_MSK:  rdata_o = {46'b0, emsk_q, 16'b0};
      OFS_ADDR:     rdata_o = {{(64-ADDR_W){1'b0}}, base_q};
      default:      rdata_o = '0;
    endcase
  end

  assign start_o = wr_i && addr_i == OFS_CTRL && wdata_i[0];
  assign mode_o  = mode_q;
  assign base_o  = base_q;
  assign rel_o   = rel_q;
  assign irq_o   = |(done_q & ~dmsk_q) | |(err_q & ~emsk_q);
endmodule

// File: rtl/sd_idma_xfer.sv
module sd_idma_xfer
  import sd_idma_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 32,
  parameter int BSZ_W  = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mode_t             mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        rel_i,
  input  logic [CNT_W-1:0]  blk_cnt_i,
  input  logic [BSZ_W-1:0]  blk_size_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  output logic              mem_rready_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_wvalid_o,
  input  logic              mem_wready_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              card_tx_valid_o,
  input  logic              card_tx_ready_i,
  output logic [DATA_W-1:0] card_tx_data_o,
  input  logic              card_rx_valid_i,
  output logic              card_rx_ready_o,
  input  logic [DATA_W-1:0] card_rx_data_i,
  output logic [1:0]        done_evt_o,
  output logic [1:0]        err_evt_o,
  output logic              busy_o,
  output logic              fire_o,
  output logic              incr_o
);
  localparam int LEN_W  = CNT_W + BSZ_W;
  localparam int BEAT_W = LEN_W - 3;

  logic              busy_q, chan_q, incr_q, run, fire;
  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] left_q, beats;
  logic [LEN_W-1:0]  len;
  logic [1:0]        done_q, err_q;

  assign len   = LEN_W'(blk_cnt_i) * LEN_W'(blk_size_i);
  assign beats = len[LEN_W-1:3];
  assign run   = busy_q && rel_i[chan_q];
  assign fire  = run && (chan_q ? (card_rx_valid_i && mem_wready_i)
                                : (mem_rvalid_i && card_tx_ready_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      chan_q <= 1'b0;
      incr_q <= 1'b0;
      addr_q <= '0;
      left_q <= '0;
      done_q <= '0;
      err_q  <= '0;
    end else begin
      done_q <= '0;
      err_q  <= '0;
      if (!busy_q) begin
        if (start_i && rel_i[mode_i.chan]) begin
          if (base_i[2:0] != 3'b0)   err_q[mode_i.chan]  <= 1'b1;
          else if (beats == '0)      done_q[mode_i.chan] <= 1'b1;
          else begin
            busy_q <= 1'b1;
            chan_q <= mode_i.chan;
            incr_q <= mode_i.incr;
            addr_q <= base_i;
            left_q <= beats;
          end
        end
      end else if (!rel_i[chan_q]) begin
        busy_q <= 1'b0;                       // abort, no completion
      end else if (fire) begin
        if (incr_q) addr_q <= addr_q + ADDR_W'(8);
        left_q <= left_q - BEAT_W'(1);
        if (left_q == BEAT_W'(1)) begin
          busy_q         <= 1'b0;
          done_q[chan_q] <= 1'b1;
        end
      end
    end
  end

  assign mem_addr_o      = addr_q;
  assign card_tx_valid_o = run && !chan_q && mem_rvalid_i;
  assign mem_rready_o    = run && !chan_q && card_tx_ready_i;
  assign card_tx_data_o  = mem_rdata_i;
  assign mem_wvalid_o    = run && chan_q && card_rx_valid_i;
  assign card_rx_ready_o = run && chan_q && mem_wready_i;
  assign mem_wdata_o     = card_rx_data_i;
  assign done_evt_o      = done_q;
  assign err_evt_o       = err_q;
  assign busy_o          = busy_q;
  assign fire_o          = fire;
  assign incr_o          = incr_q;

  logic unused_bits;
  assign unused_bits = ^{mode_i.width, len[2:0]};
endmodule

// File: rtl/sd_idma_engine.sv
module sd_idma_engine
  import sd_idma_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 32,
  parameter int BSZ_W  = 10,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [11:0]       reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  input  logic [CNT_W-1:0]  blk_cnt_i,
  input  logic [BSZ_W-1:0]  blk_size_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  output logic              mem_rready_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_wvalid_o,
  input  logic              mem_wready_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              card_tx_valid_o,
  input  logic              card_tx_ready_i,
  output logic [DATA_W-1:0] card_tx_data_o,
  input  logic              card_rx_valid_i,
  output logic              card_rx_ready_o,
  input  logic [DATA_W-1:0] card_rx_data_i,
  output logic              irq_o
);
  mode_t             mode;
  logic [ADDR_W-1:0] base;
  logic              start, busy, fire, incr;
  logic [1:0]        rel, done_evt, err_evt;

  sd_idma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .mode_o(mode), .base_o(base), .start_o(start), .rel_o(rel),
    .done_evt_i(done_evt), .err_evt_i(err_evt), .irq_o
  );

  sd_idma_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BSZ_W(BSZ_W), .DATA_W(DATA_W)) u_xfer (
    .clk_i, .rst_ni,
    .start_i(start), .mode_i(mode), .base_i(base), .rel_i(rel),
    .blk_cnt_i, .blk_size_i, .mem_addr_o,
    .mem_rvalid_i, .mem_rready_o, .mem_rdata_i,
    .mem_wvalid_o, .mem_wready_i, .mem_wdata_o,
    .card_tx_valid_o, .card_tx_ready_i, .card_tx_data_o,
    .card_rx_valid_i, .card_rx_ready_o, .card_rx_data_i,
    .done_evt_o(done_evt), .err_evt_o(err_evt),
    .busy_o(busy), .fire_o(fire), .incr_o(incr)
  );

  logic unused_obs;
  assign unused_obs = ^{busy, fire, incr};
endmodule

// File: rtl/sd_idma_chk.sv
module sd_idma_chk #(
  parameter int ADDR_W = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              card_tx_valid_o,
  input logic              mem_rready_o,
  input logic              mem_wvalid_o,
  input logic              card_rx_ready_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy,
  input logic              fire,
  input logic              incr,
  input logic [1:0]        rel,
  input logic [1:0]        done_evt,
  input logic [1:0]        err_evt
);
  assert_one_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((card_tx_valid_o || mem_rready_o) && (mem_wvalid_o || card_rx_ready_o)));

  assert_aligned_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> mem_addr_o[2:0] == 3'b0);

  assert_fixed_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !incr) |=> $stable(mem_addr_o));

  assert_step_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && incr) |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(8));

  assert_held_ch0_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel[0] |-> !card_tx_valid_o && !mem_rready_o);

  assert_held_ch1_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel[1] |-> !mem_wvalid_o && !card_rx_ready_o);

  assert_single_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_evt, err_evt}));

  assert_no_done_on_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_evt != 2'b0) |-> !busy);
endmodule

bind sd_idma_engine sd_idma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .card_tx_valid_o, .mem_rready_o, .mem_wvalid_o, .card_rx_ready_o,
  .mem_addr_o, .busy, .fire, .incr, .rel, .done_evt, .err_evt
);

// File: tb/sd_idma_engine_tb_top.sv
`timescale 1ns/1ps
module sd_idma_engine_tb_top;
  localparam logic [11:0] A_MODE = 12'h820, A_CTRL = 12'h828, A_RST = 12'h830,
                          A_DONE = 12'h840, A_DMSK = 12'h848, A_ERR = 12'h850,
                          A_EMSK = 12'h858, A_ADDR = 12'h880;

  logic        clk_i = 0, rst_ni = 0;
  logic        reg_wr_i = 0;
  logic [11:0] reg_addr_i = '0;
  logic [63:0] reg_wdata_i = '0, reg_rdata_o;
  logic [31:0] blk_cnt_i = '0;
  logic [9:0]  blk_size_i = '0;
  logic [39:0] mem_addr_o;
  logic        mem_rvalid_i = 0, mem_rready_o, mem_wvalid_o, mem_wready_i = 0;
  logic [63:0] mem_rdata_i = '0, mem_wdata_o, card_tx_data_o, card_rx_data_i = '0;
  logic        card_tx_valid_o, card_tx_ready_i = 0, card_rx_valid_i = 0, card_rx_ready_o;
  logic        irq_o;

  int tests = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  sd_idma_engine dut_i (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_addr(logic [63:0] base, bit incr, int k);
    return incr ? base + 64'(8 * k) : base;
  endfunction

  function automatic int exp_beats(int cnt, int size);
    return (cnt * size) / 8;
  endfunction

  function automatic logic [63:0] mode_word(bit ch, bit incr);
    return {47'b0, ch, 10'b0, 2'b11, 3'b0, incr};
  endfunction

  task automatic reg_wr(logic [11:0] a, logic [63:0] d);
    @(negedge clk_i);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [63:0] d);
    @(negedge clk_i);
    reg_wr_i = 0; reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic idle_inputs();
    mem_rvalid_i = 0; card_tx_ready_i = 0; card_rx_valid_i = 0; mem_wready_i = 0;
  endtask

  task automatic start_xfer(bit ch, bit incr, logic [63:0] base, int cnt, int size);
    blk_cnt_i = 32'(cnt); blk_size_i = 10'(size);
    reg_wr(A_MODE, mode_word(ch, incr));
    reg_wr(A_ADDR, base);
    reg_wr(A_CTRL, 64'h1);
  endtask

  // Drive beats [from, n) with random stalls; called at a negedge.
  task automatic do_beats(bit ch, bit incr, logic [63:0] base, int from, int n);
    int k = from;
    for (int guard = 0; guard < 5000 && k < n; guard++) begin
      bit v = 1'($urandom % 2), r = 1'($urandom % 2);
      logic [63:0] d = {$urandom, $urandom};
      if (ch) begin card_rx_valid_i = v; mem_wready_i = r; card_rx_data_i = d; end
      else    begin mem_rvalid_i = v; card_tx_ready_i = r; mem_rdata_i = d; end
      #1;
      if (!ch && card_tx_valid_o && card_tx_ready_i) begin
        chk("R5 addr", 64'(mem_addr_o), exp_addr(base, incr, k));
        chk("R3 tx data", card_tx_data_o, d);
        k++;
      end else if (ch && mem_wvalid_o && mem_wready_i) begin
        chk("R5 addr", 64'(mem_addr_o), exp_addr(base, incr, k));
        chk("R3 rx data", mem_wdata_o, d);
        k++;
      end
      @(negedge clk_i);
    end
    chk("R4 beats issued", 64'(k), 64'(n));
    idle_inputs();
  endtask

  task automatic no_more_beats(string req);
    @(negedge clk_i);
    mem_rvalid_i = 1; card_tx_ready_i = 1; card_rx_valid_i = 1; mem_wready_i = 1;
    #1 chk(req, {card_tx_valid_o, mem_rready_o, mem_wvalid_o, card_rx_ready_o}, 0);
    idle_inputs();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    void'($urandom(32'h5eed_1234));
    #23 rst_ni = 1;

    // R1 reset state
    reg_rd(A_MODE, rd); chk("R1 mode", rd, 0);
    reg_rd(A_RST, rd);  chk("R1 rst", rd, 64'h300);
    reg_rd(A_DONE, rd); chk("R1 done", rd, 0);
    reg_rd(A_ERR, rd);  chk("R1 err", rd, 0);
    reg_rd(A_ADDR, rd); chk("R1 addr", rd, 0);
    chk("R1 irq", 64'(irq_o), 0);
    no_more_beats("R1 idle outputs");

    // R2 mode readback keeps only defined bits
    reg_wr(A_MODE, 64'hFFFF_0000_0001_0031 | 64'hC0);
    reg_rd(A_MODE, rd); chk("R2 mode bits", rd, 64'h1_0031);

    // R3/R4/R5/R6 channel 0 increment, 8 beats
    start_xfer(0, 1, 64'h1000, 4, 16);
    do_beats(0, 1, 64'h1000, 0, exp_beats(4, 16));
    no_more_beats("R4 no extra beats");
    reg_rd(A_DONE, rd); chk("R6 ch0 done", rd, 64'h1_0000);
    chk("R11 irq on done", 64'(irq_o), 1);
    reg_wr(A_DMSK, 64'h1_0000);
    @(negedge clk_i); chk("R11 masked", 64'(irq_o), 0);
    reg_wr(A_DONE, 64'h0);
    reg_rd(A_DONE, rd); chk("R8 clear by zero", rd, 0);
    reg_wr(A_DMSK, 64'h0);

    // R5 channel 1 fixed address, 3 beats
    start_xfer(1, 0, 64'h2008, 3, 8);
    do_beats(1, 0, 64'h2008, 0, 3);
    reg_rd(A_DONE, rd); chk("R6 ch1 done", rd, 64'h2_0000);
    reg_wr(A_DONE, 64'h2_0000);
    reg_rd(A_DONE, rd); chk("R8 write one keeps", rd, 64'h2_0000);
    reg_wr(A_DONE, 64'h0);

    // R7 misaligned start
    start_xfer(0, 1, 64'h1004, 2, 8);
    no_more_beats("R7 no beats");
    reg_rd(A_ERR, rd);  chk("R7 err ch0", rd, 64'h1_0000);
    reg_rd(A_DONE, rd); chk("R7 no done", rd, 0);
    chk("R11 irq on err", 64'(irq_o), 1);
    reg_wr(A_EMSK, 64'h1_0000);
    @(negedge clk_i); chk("R11 err masked", 64'(irq_o), 0);
    reg_wr(A_ERR, 64'h0); reg_wr(A_EMSK, 64'h0);

    // R4 zero-length transfer completes at once
    start_xfer(1, 1, 64'h40, 1, 4);
    no_more_beats("R4 zero len no beats");
    reg_rd(A_DONE, rd); chk("R4 zero len done", rd, 64'h2_0000);
    reg_wr(A_DONE, 64'h0);

    // R9 abort mid-transfer, start on held channel ignored
    start_xfer(0, 1, 64'h4000, 10, 8);
    do_beats(0, 1, 64'h4000, 0, 3);
    reg_wr(A_RST, 64'h0);
    reg_wr(A_CTRL, 64'h1);
    reg_wr(A_RST, 64'h300);
    no_more_beats("R9 aborted");
    reg_rd(A_DONE, rd); chk("R9 no done after abort", rd, 0);
    reg_wr(A_RST, 64'h100);
    start_xfer(1, 1, 64'h80, 1, 8);
    reg_wr(A_RST, 64'h300);
    no_more_beats("R9 held start ignored");

    // R10 start while busy ignored
    start_xfer(0, 1, 64'h3000, 4, 8);
    do_beats(0, 1, 64'h3000, 0, 1);
    reg_wr(A_MODE, mode_word(1, 0));
    reg_wr(A_ADDR, 64'h5000);
    reg_wr(A_CTRL, 64'h1);
    do_beats(0, 1, 64'h3000, 1, 4);
    no_more_beats("R10 original count kept");
    reg_rd(A_DONE, rd); chk("R10 ch0 done only", rd, 64'h1_0000);
    reg_wr(A_DONE, 64'h0);

    // R8 set and clear in the same cycle
    start_xfer(1, 1, 64'h100, 1, 8);
    do_beats(1, 1, 64'h100, 0, 1);
    start_xfer(0, 1, 64'h200, 1, 8);
    mem_rvalid_i = 1; card_tx_ready_i = 1;
    @(negedge clk_i);
    idle_inputs();
    reg_wr_i = 1; reg_addr_i = A_DONE; reg_wdata_i = 64'h0;
    @(negedge clk_i);
    reg_wr_i = 0;
    reg_rd(A_DONE, rd); chk("R8 set wins over clear", rd, 64'h1_0000);
    reg_wr(A_DONE, 64'h0);

    // random transfers
    for (int t = 0; t < 20; t++) begin
      bit ch = 1'($urandom % 2), inc = 1'($urandom % 2);
      int cnt = 1 + int'($urandom % 6);
      int sz = 8 * (1 + int'($urandom % 8));
      logic [63:0] base = 64'($urandom % 4096) << 3;
      start_xfer(ch, inc, base, cnt, sz);
      do_beats(ch, inc, base, 0, exp_beats(cnt, sz));
      reg_rd(A_DONE, rd); chk("R6 random done", rd, ch ? 64'h2_0000 : 64'h1_0000);
      reg_wr(A_DONE, 64'h0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule